// File: doc/BRIEF.md
# Command Ring Parser

The block reads a ring of 32-bit command words out of memory, one word per read, starting at a get pointer. It stops when get reaches a put pointer that the host writes. Each word at get is decoded as a header. A method header becomes one or more (register, value, location) writes, which leave on a valid/ready stream. A control header changes get directly: it can be a NOP, a jump, a call or a return. Only one return address is held, so calls cannot nest. A burst that would read past put is cut short. A malformed or unknown header sets a sticky error flag.

The host writes put to publish new work. It writes get to restart the parser, which also clears the error flag and drops any burst in progress. Command memory uses a synchronous read port: the data for an address appears one cycle after the read strobe.

Top module: `cmd_stream_parser`

## Requirements
- R1: After reset, get and put are 0, `empty` is high and `out_valid` is low. Whenever the parser is idle, has no error and get equals put, `empty` is high and no write is issued.
- R2: A method header is any word other than 0 whose bits {31,30,29,17,16,1,0} are all clear, or whose bits in that set equal exactly bit 30. It carries a count in bits 28:18 and a start register in bits 15:2 (register byte address = header & 0xFFFC). A count of n > 1 produces n writes and advances get by 4n+4. A count of 0 or 1 produces one write and advances get by 8. Argument k (from 0) is the word at header address + 4 + 4k. Every write carries the header address as its location.
- R3: If bit 30 is set in a method header, every write uses the start register. Otherwise the register rises by 4 for each argument.
- R4: If the header and its n arguments need more than put−get bytes (4n+4 > put−get, for n > 1), the count is reduced to (put−get)/4 − 1.
- R5: If put−get is below 8 at a method header, the header is not consumed. Nothing is emitted and get does not move until more words are put.
- R6: The header 0x00000000 is a NOP: get advances by 4 and nothing is emitted.
- R7: A header with (h & 0xE0000003) == 0x20000000 is an old-form jump: get becomes h & 0x1FFFFFFC.
- R8: A header with low bits 01 is a new-form jump: get becomes h & 0xFFFFFFFC.
- R9: A header with low bits 10 is a call. With no saved address, it saves header address + 4 and sets get to h & 0xFFFFFFFC. With an address already saved, the call is dropped, get becomes the saved address and the saved address is cleared.
- R10: The header 0x00020000 is a return. It sets get to the saved address and clears it. With none saved, it sets get equal to put, which discards the queued work.
- R11: Any other word with a bit of 0xE0030003 set raises `error`. This includes low bits 11. In that case get is not advanced, no memory read is issued while `error` is high, and `error` stays high until the host writes get.
- R12: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_reg`, `out_value` and `out_loc` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| put_we | input | 1 | Host write strobe for put |
| put_wdata | input | 32 | New put byte address |
| get_we | input | 1 | Host write strobe for get (restarts parser, clears error) |
| get_wdata | input | 32 | New get byte address |
| put_q | output | 32 | Current put pointer |
| get_q | output | 32 | Current get pointer |
| mem_re | output | 1 | Command memory read strobe |
| mem_addr | output | 32 | Command memory byte address |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_re |
| out_valid | output | 1 | Register write available |
| out_ready | input | 1 | Consumer accepts the write |
| out_reg | output | 16 | Register byte address |
| out_value | output | 32 | Argument value |
| out_loc | output | 32 | Address of the header that produced the write |
| empty | output | 1 | Idle with get equal to put |
| error | output | 1 | Sticky error flag |

## Verification
The embedded assertions check four things on every cycle: the output stream holds steady under backpressure, the error flag stays set until get is written, no memory read happens while the error is set, and `empty` never coincides with a pending write. Burst clamping, the register step, the jump target masks and the single-level call and return recovery rules can only be shown by the bench scenarios. In those scenarios a bench model walks the same memory, and its write sequence, final get and error state are compared against the design's.

// File: rtl/cmd_stream_parser.sv
module cmd_stream_parser (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        put_we,
  input  logic [31:0] put_wdata,
  input  logic        get_we,
  input  logic [31:0] get_wdata,
  output logic [31:0] put_q,
  output logic [31:0] get_q,
  output logic        mem_re,
  output logic [31:0] mem_addr,
  input  logic [31:0] mem_rdata,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [15:0] out_reg,
  output logic [31:0] out_value,
  output logic [31:0] out_loc,
  output logic        empty,
  output logic        error
);
  localparam logic [31:0] CTRL_MASK = 32'hE003_0003;
  localparam logic [31:0] FIXED_REG = 32'h4000_0000;
  localparam logic [31:0] RET_WORD  = 32'h0002_0000;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_AREQ, S_ADAT, S_OUT} st_t;
  st_t st;

  logic [31:0] get_r, put_r, ret_r, arg_p;
  logic        ret_v, err_r, fixed;
  logic [10:0] rem;

  wire [31:0] hdr     = mem_rdata;
  wire [31:0] ctl     = hdr & CTRL_MASK;
  wire        is_ctl  = (ctl != 32'h0) && (ctl != FIXED_REG);
  wire        old_jmp = (hdr & 32'hE000_0003) == 32'h2000_0000;
  wire [31:0] avail   = put_r - get_r;
  wire        short_q = avail < 32'd8;
  wire [29:0] room    = avail[31:2] - 30'd1;
  wire [10:0] cnt     = hdr[28:18];
  wire [10:0] n_eff   = (cnt <= 11'd1) ? 11'd1 :
                        ({19'd0, cnt} > room) ? room[10:0] : cnt;

  assign put_q    = put_r;
  assign get_q    = get_r;
  assign error    = err_r;
  assign empty    = (st == S_IDLE) && !err_r && (get_r == put_r);
  assign mem_re   = ((st == S_IDLE) && !err_r && (get_r != put_r) && !get_we) || (st == S_AREQ);
  assign mem_addr = (st == S_AREQ) ? arg_p : get_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; get_r <= '0; put_r <= '0; ret_r <= '0; ret_v <= 1'b0;
      err_r <= 1'b0; arg_p <= '0; fixed <= 1'b0; rem <= '0;
      out_valid <= 1'b0; out_reg <= '0; out_value <= '0; out_loc <= '0;
    end else begin
      if (put_we) put_r <= put_wdata;
      if (get_we) begin
        get_r <= get_wdata; st <= S_IDLE; err_r <= 1'b0; out_valid <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (!err_r && get_r != put_r) st <= S_HDR;
          S_HDR: begin
            st <= S_IDLE;
            if (is_ctl) begin
              if (old_jmp) get_r <= hdr & 32'h1FFF_FFFC;
              else if (hdr[1:0] == 2'b01) get_r <= {hdr[31:2], 2'b00};
              else if (hdr[1:0] == 2'b10) begin
                if (ret_v) begin
                  get_r <= ret_r; ret_v <= 1'b0;
                end else begin
                  ret_r <= get_r + 32'd4; ret_v <= 1'b1; get_r <= {hdr[31:2], 2'b00};
                end
              end else if (hdr == RET_WORD) begin
                if (ret_v) begin
                  get_r <= ret_r; ret_v <= 1'b0;
                end else get_r <= put_r;
              end else err_r <= 1'b1;
            end else if (hdr == 32'h0) begin
              get_r <= get_r + 32'd4;
            end else if (!short_q) begin
              get_r   <= get_r + {19'd0, n_eff, 2'b00} + 32'd4;
              arg_p   <= get_r + 32'd4;
              out_loc <= get_r;
              out_reg <= {hdr[15:2], 2'b00};
              fixed   <= hdr[30];
              rem     <= n_eff;
              st      <= S_AREQ;
            end
          end
          S_AREQ: st <= S_ADAT;
          S_ADAT: begin
            out_value <= mem_rdata; out_valid <= 1'b1; st <= S_OUT;
          end
          S_OUT: if (out_ready) begin
            out_valid <= 1'b0;
            arg_p <= arg_p + 32'd4;
            if (!fixed) out_reg <= out_reg + 16'd4;
            rem <= rem - 11'd1;
            st  <= (rem == 11'd1) ? S_IDLE : S_AREQ;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R12
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !get_we) |=>
      (out_valid && $stable(out_value) && $stable(out_reg) && $stable(out_loc)));
  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_r && !get_we) |=> err_r);
  // R11
  err_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_r |-> !mem_re);
  // R1
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (!out_valid && !mem_re));
endmodule

// File: tb/cmd_stream_parser_test.sv
module cmd_stream_parser_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        put_we = 1'b0, get_we = 1'b0;
  logic [31:0] put_wdata = '0, get_wdata = '0;
  logic [31:0] put_q, get_q, mem_addr, out_value, out_loc;
  logic [31:0] mem_rdata = '0;
  logic        mem_re, out_valid, empty, error;
  logic        out_ready = 1'b0;
  logic [15:0] out_reg;

  always #2 clk = ~clk;

  cmd_stream_parser uut (
    .clk(clk), .rst_n(rst_n), .put_we(put_we), .put_wdata(put_wdata),
    .get_we(get_we), .get_wdata(get_wdata), .put_q(put_q), .get_q(get_q),
    .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_reg(out_reg),
    .out_value(out_value), .out_loc(out_loc), .empty(empty), .error(error));

  logic [31:0] mem [0:255];
  always @(posedge clk) if (mem_re) mem_rdata <= mem[mem_addr[9:2]];

  int checks = 0, errors = 0;
  int cycles = 0;
  bit finished = 0;

  logic [15:0] exp_reg [0:1023];
  logic [31:0] exp_val [0:1023];
  logic [31:0] exp_loc [0:1023];
  int          en;
  logic [31:0] eg;
  bit          eerr, estall;
  bit          m_rv = 0;
  logic [31:0] m_ra = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] g0, input logic [31:0] p0);
    logic [31:0] g, h, loc, av, a;
    int cnt, ne, steps, room;
    g = g0; en = 0; eerr = 0; estall = 0; steps = 0;
    while (g != p0 && !eerr && !estall && steps < 500) begin
      steps++;
      h = mem[g[9:2]]; loc = g;
      if ((h & 32'hE0030003) != 0 && (h & 32'hE0030003) != 32'h40000000) begin
        if ((h & 32'hE0000003) == 32'h20000000) g = h & 32'h1FFFFFFC;
        else if (h[1:0] == 2'b01) g = h & 32'hFFFFFFFC;
        else if (h[1:0] == 2'b10) begin
          if (m_rv) begin g = m_ra; m_rv = 0; end
          else begin m_ra = loc + 4; m_rv = 1; g = h & 32'hFFFFFFFC; end
        end else if (h == 32'h00020000) begin
          if (m_rv) begin g = m_ra; m_rv = 0; end else g = p0;
        end else eerr = 1;
      end else if (h == 0) g = g + 4;
      else begin
        av = p0 - g;
        if (av < 8) estall = 1;
        else begin
          cnt = int'(h[28:18]);
          room = int'(av[31:2]) - 1;
          if (cnt <= 1) ne = 1; else if (cnt > room) ne = room; else ne = cnt;
          for (int i = 0; i < ne; i++) begin
            a = g + 4 + 4 * i;
            exp_reg[en] = h[30] ? (h[15:0] & 16'hFFFC) : ((h[15:0] & 16'hFFFC) + 16'(4 * i));
            exp_val[en] = mem[a[9:2]];
            exp_loc[en] = loc;
            en++;
          end
          g = g + 4 * ne + 4;
        end
      end
    end
    eg = g;
  endtask

  task automatic run(input logic [31:0] g0, input logic [31:0] p0, input string req);
    int got = 0;
    bit done = 0, hv = 0;
    logic [15:0] hreg;
    logic [31:0] hval, hloc;
    model(g0, p0);
    @(negedge clk);
    get_we = 1; get_wdata = g0; put_we = 1; put_wdata = p0;
    @(negedge clk);
    get_we = 0; put_we = 0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (hv) chk(out_valid && out_value == hval && out_reg == hreg && out_loc == hloc,
                  "R12", "held output", out_value, hval);
      out_ready = ($urandom % 10) < 7;
      hv = out_valid && !out_ready;
      hreg = out_reg; hval = out_value; hloc = out_loc;
      if (out_valid && out_ready) begin
        if (got < en) begin
          chk(out_reg == exp_reg[got], req, "out_reg", {16'd0, out_reg}, {16'd0, exp_reg[got]});
          chk(out_value == exp_val[got], req, "out_value", out_value, exp_val[got]);
          chk(out_loc == exp_loc[got], req, "out_loc", out_loc, exp_loc[got]);
        end else chk(0, req, "extra write", {16'd0, out_reg}, 32'd0);
        got++;
      end
      if (!estall && c > 1 && (empty || error) && !(out_valid && out_ready)) begin done = 1; break; end
      if (estall && c >= 200) begin done = 1; break; end
    end
    out_ready = 0;
    chk(done, req, "completion", 32'(done), 32'd1);
    chk(got == en, req, "write count", 32'(got), 32'(en));
    chk(get_q == eg, req, "final get", get_q, eg);
    chk(error == eerr, req, "error flag", 32'(error), 32'(eerr));
    if (estall) chk(!out_valid && !empty, "R5", "stalled outputs", 32'(out_valid), 32'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !finished) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(empty == 1'b1, "R1", "empty after reset", 32'(empty), 32'd1);
    chk(error == 1'b0 && out_valid == 1'b0, "R1", "error/valid after reset", {error, out_valid}, 32'd0);
    chk(get_q == 0 && put_q == 0, "R1", "pointers after reset", get_q | put_q, 32'd0);

    // R2 incrementing burst
    mem[0] = (32'd3 << 18) | 32'h0100;
    run(32'h0, 32'h10, "R2");
    // R3 fixed register burst
    mem[8] = 32'h40000000 | (32'd2 << 18) | 32'h0204;
    run(32'h20, 32'h2C, "R3");
    // R6 NOPs then count-0 method
    mem[16] = 0; mem[17] = 0; mem[18] = 32'h0088;
    run(32'h40, 32'h50, "R6");
    chk(eg == 32'h50 && en == 1, "R6", "model nop walk", eg, 32'h50);
    // R4 clamp
    mem[24] = (32'd5 << 18) | 32'h0300;
    run(32'h60, 32'h6C, "R4");
    chk(en == 2, "R4", "clamped count", 32'(en), 32'd2);
    // R5 stall then release
    mem[32] = (32'd3 << 18) | 32'h0010;
    run(32'h80, 32'h84, "R5");
    run(32'h80, 32'h90, "R5");
    // R7 old jump
    mem[40] = 32'h200000C0; mem[41] = (32'd1 << 18) | 32'h0700;
    mem[48] = (32'd1 << 18) | 32'h0050;
    run(32'hA0, 32'hC8, "R7");
    // R8 new jump
    mem[52] = 32'h000000E1; mem[53] = (32'd1 << 18) | 32'h0704;
    mem[56] = (32'd2 << 18) | 32'h0060;
    run(32'hD0, 32'hEC, "R8");
    // R9 / R10 call and return
    mem[64] = 32'h00000182; mem[65] = (32'd1 << 18) | 32'h0048;
    mem[96] = (32'd1 << 18) | 32'h0044; mem[98] = 32'h00020000;
    run(32'h100, 32'h10C, "R9");
    // R9 nested call dropped, then R10 return with none saved
    mem[68] = 32'h000001A2; mem[69] = 32'h00020000;
    mem[70] = (32'd1 << 18) | 32'h0070;
    mem[104] = 32'h000001C2; mem[112] = (32'd1 << 18) | 32'h0074;
    run(32'h110, 32'h120, "R9");
    chk(en == 0 && eg == 32'h120, "R10", "discarded queue", eg, 32'h120);
    // R10 bare return
    mem[76] = (32'd1 << 18) | 32'h0080; mem[78] = 32'h00020000;
    mem[79] = (32'd1 << 18) | 32'h0084;
    run(32'h130, 32'h148, "R10");
    // R11 errors and recovery
    mem[84] = 32'h00000000 | 32'h0090; mem[86] = 32'h00000003;
    run(32'h150, 32'h170, "R11");
    mem[88] = 32'h00010000;
    run(32'h160, 32'h170, "R11");
    repeat (4) @(negedge clk);
    chk(error == 1'b1 && get_q == 32'h160, "R11", "sticky error", get_q, 32'h160);
    mem[92] = (32'd1 << 18) | 32'h0094;
    run(32'h170, 32'h178, "R11");

    // random programs
    for (int t = 0; t < 40; t++) begin
      int pos = 0, len;
      len = 4 + int'($urandom % 24);
      while (pos < len) begin
        int k = int'($urandom % 10);
        if (k == 0) begin mem[128 + pos] = 0; pos++; end
        else if (k == 1 && t % 5 == 0) begin mem[128 + pos] = 32'h3; pos++; end
        else begin
          int c = int'($urandom % 6);
          mem[128 + pos] = ($urandom % 2 ? 32'h40000000 : 32'h0) | (32'(c) << 18) |
                           ({$urandom} & 32'hFFFC) | 32'h4;
          pos = pos + 1 + ((c == 0) ? 1 : c);
        end
      end
      run(32'h200, 32'h200 + 32'(4 * len), (t % 2) ? "R2" : "R4");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule